// File: doc/BRIEF.md
# Eight-bit Integer ALU with Status Flags

This block is the arithmetic and logic stage of a small eight-bit processor core. Each cycle the core can present one operation. An operation takes a register operand `opnd_a`, a second register operand `opnd_b` or an eight-bit immediate `imm`, a bit index, and the current status byte. One clock edge later the block returns the result byte, a write-enable for the destination register, and the complete next status byte.

Several flag rules are chosen so that multi-byte arithmetic needs no extra instructions. Increment and decrement leave the carry alone, so a loop counter can run between carry-chained steps. The carry-chained subtract and compare operations can clear the zero flag but can never set it. As a result, a plain compare followed by three chained compares leaves zero set only when the whole 32-bit difference is zero.

Fetch, decode, the register file and memory access are outside the block. The core feeds `status_out` back into `status_in` and writes `result` only when `wr_en` is high.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 0) and ADC (op 1) return a+b+cin, where cin is status C for ADC and 0 for ADD. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on signed overflow. N is result bit 7 and Z is set when the result is zero.
- R2: SUB (op 2), SBC (op 3), SUBI (op 4), SBCI (op 5), CPC (op 6) and CP (op 7) compute a-b-cin, where cin is status C for SBC, SBCI and CPC and 0 otherwise. C is set when b+cin exceeds a as unsigned values, H is set on a borrow out of bit 3, and V is set on signed overflow.
- R3: SBC, SBCI and CPC never set Z. With a zero result they keep the incoming Z, and with a non-zero result they clear it. A CP followed by three CPC ops, with status fed back each time, ends with Z set only when all 32 bits are equal.
- R4: CP and CPC update flags but hold `wr_en` low, and `result` still shows the difference. Their codes differ only in op bit 0, which is the inverse of the with-carry choice: 0 selects with-carry.
- R5: INC (op 8) returns a+1 and DEC (op 9) returns a-1. Both leave C and H unchanged. V is set for INC of 0x7F and for DEC of 0x80.
- R6: AND (op 10), OR (op 11) and XOR (op 12) clear V, leave C and H unchanged, and update N, Z and S.
- R7: BST (op 13) copies bit `bit_sel` of `opnd_a` into T and leaves `wr_en` low and `result` equal to `opnd_a`. BLD (op 14) returns `opnd_a` with bit `bit_sel` replaced by T, with `wr_en` high and all flags unchanged.
- R8: Every op that updates N or V sets S to N XOR V.
- R9: SUBI and SBCI take their second operand from `imm` and ignore `opnd_b`. All other ops ignore `imm`.
- R10: Op 15 is reserved. It returns `opnd_a`, holds `wr_en` low and passes the status byte through unchanged.
- R11: Outputs are registered with one cycle of latency. A synchronous active-low reset clears `out_valid`, `result`, `wr_en` and `status_out`. A cycle without `in_valid` gives a low `wr_en`.
- R12: The status byte places C at bit 0, Z at bit 1, N at bit 2, V at bit 3, S at bit 4, H at bit 5 and T at bit 6. Bit 7 is never modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| opnd_a | input | 8 | First register operand and destination value |
| opnd_b | input | 8 | Second register operand |
| imm | input | 8 | Immediate operand for SUBI and SBCI |
| bit_sel | input | 3 | Bit index for BST and BLD |
| status_in | input | 8 | Current status byte |
| out_valid | output | 1 | Registered outputs belong to an operation |
| result | output | 8 | Registered result byte |
| wr_en | output | 1 | Destination write-enable |
| status_out | output | 8 | Next status byte |

## Verification
Nearly all of the block's decisions are combinational before the single output register, so a wrong borrow, half-carry or overflow term appears in `status_out` exactly one cycle after the offending operation. The zero-flag chaining rule can hide an error for several operations. The 32-bit chained compares are therefore checked at the end of the chain, where a wrongly set Z in the low byte would show up three operations later as a false equality. Random operands and random incoming status are compared against an independent model, which exposes flags that are wrongly kept or wrongly overwritten.

// File: rtl/alu8_pkg.sv
// Package: operation codes and status bit positions shared by the ALU
// modules. Assumes an eight-bit status byte whose bit order is decoded by
// the surrounding core.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ADC  = 4'h1,
        OP_SUB  = 4'h2,
        OP_SBC  = 4'h3,
        OP_SUBI = 4'h4,
        OP_SBCI = 4'h5,
        OP_CPC  = 4'h6,   // bit 0 low: with carry
        OP_CP   = 4'h7,   // bit 0 high: without carry
        OP_INC  = 4'h8,
        OP_DEC  = 4'h9,
        OP_AND  = 4'hA,
        OP_OR   = 4'hB,
        OP_XOR  = 4'hC,
        OP_BST  = 4'hD,
        OP_BLD  = 4'hE,
        OP_RSVD = 4'hF
    } alu_op_e;

    localparam int STATUS_W = 8;
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int FLG_T = 6;

endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor: computes a+b+cin or a-b-cin and returns the carry or
// borrow out of the top bit, the carry or borrow out of the lower half,
// and signed overflow. Assumes DATA_W is even.
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [HALF_W:0] low;
    logic            a_top, b_top, r_top;

    // Purpose: full-width and half-width sums or differences.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[HALF_W-1:0]} - {1'b0, b[HALF_W-1:0]} - {{HALF_W{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        end
    end

    assign res   = full[DATA_W-1:0];
    assign c_out = full[DATA_W];
    assign h_out = low[HALF_W];
    assign a_top = a[DATA_W-1];
    assign b_top = b[DATA_W-1];
    assign r_top = full[DATA_W-1];

    // Purpose: signed overflow from operand and result sign bits.
    always_comb begin
        if (sub) v_out = (a_top & ~b_top & ~r_top) | (~a_top & b_top & r_top);
        else     v_out = (a_top &  b_top & ~r_top) | (~a_top & ~b_top & r_top);
    end

endmodule

// File: rtl/alu8_logic.sv
// Logic and bit unit: AND/OR/XOR, T-bit insertion for BLD and T-bit
// extraction for BST. Assumes bit_sel is below DATA_W.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SEL_W-1:0]  sel,
    input  logic              t_in,
    output logic [DATA_W-1:0] res,
    output logic              t_bit
);
    logic [DATA_W-1:0] ins;

    // One insertion mux per bit position for BLD.
    for (genvar i = 0; i < DATA_W; i++) begin : g_ins
        assign ins[i] = (sel == SEL_W'(i)) ? t_in : a[i];
    end

    assign t_bit = a[sel];

    // Purpose: pick the logic or bit result for the current op.
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_BLD:  res = ins;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_flags.sv
// Flag merge: builds the next status byte and write-enable from the op and
// the unit outputs. Assumes status layout from alu8_pkg; bit 7 passes through.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e               op,
    input  logic [STATUS_W-1:0]   status_in,
    input  logic [DATA_W-1:0]     res,
    input  logic                  c_ar,
    input  logic                  h_ar,
    input  logic                  v_ar,
    input  logic                  t_bit,
    output logic [STATUS_W-1:0]   status_nxt,
    output logic                  wr_en
);
    logic zero, neg;

    assign zero = (res == '0);
    assign neg  = res[DATA_W-1];

    // Purpose: per-op flag update rules and destination write decision.
    always_comb begin
        status_nxt = status_in;
        wr_en      = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SUBI: begin
                status_nxt[FLG_C] = c_ar;
                status_nxt[FLG_H] = h_ar;
                status_nxt[FLG_V] = v_ar;
                status_nxt[FLG_N] = neg;
                status_nxt[FLG_Z] = zero;
                status_nxt[FLG_S] = neg ^ v_ar;
                wr_en             = 1'b1;
            end
            OP_SBC, OP_SBCI, OP_CPC, OP_CP: begin
                status_nxt[FLG_C] = c_ar;
                status_nxt[FLG_H] = h_ar;
                status_nxt[FLG_V] = v_ar;
                status_nxt[FLG_N] = neg;
                status_nxt[FLG_S] = neg ^ v_ar;
                status_nxt[FLG_Z] = (op == OP_CP) ? zero : (zero & status_in[FLG_Z]);
                wr_en             = (op == OP_SBC) || (op == OP_SBCI);
            end
            OP_INC, OP_DEC: begin
                status_nxt[FLG_V] = v_ar;
                status_nxt[FLG_N] = neg;
                status_nxt[FLG_Z] = zero;
                status_nxt[FLG_S] = neg ^ v_ar;
                wr_en             = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                status_nxt[FLG_V] = 1'b0;
                status_nxt[FLG_N] = neg;
                status_nxt[FLG_Z] = zero;
                status_nxt[FLG_S] = neg;
                wr_en             = 1'b1;
            end
            OP_BST:  status_nxt[FLG_T] = t_bit;
            OP_BLD:  wr_en = 1'b1;
            default: wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
// Top: eight-bit ALU with registered result, write-enable and status.
// Selects operands and carry-in per op, runs the adder and logic units,
// merges flags and registers everything with one cycle of latency.
// Assumes the caller feeds status_out back into status_in.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          op,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [DATA_W-1:0]   imm,
    input  logic [SEL_W-1:0]    bit_sel,
    input  logic [STATUS_W-1:0] status_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                wr_en,
    output logic [STATUS_W-1:0] status_out
);
    alu_op_e             op_e;
    logic [DATA_W-1:0]   b_eff, ar_res, lg_res, res_sel;
    logic                cin, sub, c_ar, h_ar, v_ar, t_bit, we_nxt;
    logic [STATUS_W-1:0] st_nxt;
    logic                out_valid_q, wr_en_q;
    logic [DATA_W-1:0]   result_q;
    logic [STATUS_W-1:0] status_q;

    assign op_e = alu_op_e'(op);

    // Purpose: choose second operand, carry-in and direction per op.
    always_comb begin
        b_eff = opnd_b;
        cin   = 1'b0;
        sub   = 1'b0;
        unique case (op_e)
            OP_ADC:           cin = status_in[FLG_C];
            OP_SUB, OP_CP:    sub = 1'b1;
            OP_SBC, OP_CPC: begin
                sub = 1'b1;
                cin = status_in[FLG_C];
            end
            OP_SUBI: begin
                sub   = 1'b1;
                b_eff = imm;
            end
            OP_SBCI: begin
                sub   = 1'b1;
                b_eff = imm;
                cin   = status_in[FLG_C];
            end
            OP_INC:           b_eff = DATA_W'(1);
            OP_DEC: begin
                sub   = 1'b1;
                b_eff = DATA_W'(1);
            end
            default:          b_eff = opnd_b;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a     (opnd_a),
        .b     (b_eff),
        .cin   (cin),
        .sub   (sub),
        .res   (ar_res),
        .c_out (c_ar),
        .h_out (h_ar),
        .v_out (v_ar)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .op    (op_e),
        .a     (opnd_a),
        .b     (opnd_b),
        .sel   (bit_sel),
        .t_in  (status_in[FLG_T]),
        .res   (lg_res),
        .t_bit (t_bit)
    );

    // Purpose: route the arithmetic or logic result to the output.
    always_comb begin
        if (op_e <= OP_DEC) res_sel = ar_res;
        else                res_sel = lg_res;
    end

    alu8_flags #(.DATA_W(DATA_W)) u_flags (
        .op         (op_e),
        .status_in  (status_in),
        .res        (res_sel),
        .c_ar       (c_ar),
        .h_ar       (h_ar),
        .v_ar       (v_ar),
        .t_bit      (t_bit),
        .status_nxt (st_nxt),
        .wr_en      (we_nxt)
    );

    // Purpose: output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            wr_en_q     <= 1'b0;
            result_q    <= '0;
            status_q    <= '0;
        end else begin
            out_valid_q <= in_valid;
            wr_en_q     <= in_valid & we_nxt;
            if (in_valid) begin
                result_q <= res_sel;
                status_q <= st_nxt;
            end
        end
    end

    assign out_valid  = out_valid_q;
    assign wr_en      = wr_en_q;
    assign result     = result_q;
    assign status_out = status_q;

endmodule

// File: rtl/alu8_core_chk.sv
// Checker: temporal properties on the ALU ports, bound into alu8_core.
// Assumes the status layout of alu8_pkg.
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [3:0]          op,
    input logic [DATA_W-1:0]   opnd_a,
    input logic [SEL_W-1:0]    bit_sel,
    input logic [STATUS_W-1:0] status_in,
    input logic                wr_en,
    input logic [STATUS_W-1:0] status_out
);
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_INC || op == OP_DEC)) |=> status_out[FLG_C] == $past(status_in[FLG_C])); // R5
    AST_CHAIN_Z_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SBC || op == OP_SBCI || op == OP_CPC) && !status_in[FLG_Z]) |=> !status_out[FLG_Z]); // R3
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CP || op == OP_CPC)) |=> !wr_en); // R4
    AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !status_out[FLG_V]); // R6
    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op < OP_BST) |=> status_out[FLG_S] == (status_out[FLG_N] ^ status_out[FLG_V])); // R8
    AST_BST_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_BST) |=> status_out[FLG_T] == $past(opnd_a[bit_sel])); // R7
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_RSVD) |=> (!wr_en && status_out == $past(status_in))); // R10
    AST_TOP_BIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> status_out[STATUS_W-1] == $past(status_in[STATUS_W-1])); // R12
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_en); // R11
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .opnd_a     (opnd_a),
    .bit_sel    (bit_sel),
    .status_in  (status_in),
    .wr_en      (wr_en),
    .status_out (status_out)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
// Bench: vector table, random comparison against an independent model,
// reset and chained 32-bit compare cases.
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op = 4'h0;
    logic [7:0] opnd_a = 8'h0, opnd_b = 8'h0, imm = 8'h0;
    logic [2:0] bit_sel = 3'h0;
    logic [7:0] status_in = 8'h0;
    logic       out_valid, wr_en;
    logic [7:0] result, status_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .bit_sel(bit_sel),
        .status_in(status_in), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .status_out(status_out)
    );

    // {op, a, b, imm, sel, status_in, exp_result, exp_we, exp_status}
    localparam int NV = 16;
    localparam logic [55:0] VEC [NV] = '{
        {4'h0, 8'h7F, 8'h01, 8'h00, 3'd0, 8'h00, 8'h80, 1'b1, 8'h2C},
        {4'h1, 8'hFF, 8'h00, 8'h00, 3'd0, 8'h01, 8'h00, 1'b1, 8'h23},
        {4'h2, 8'h10, 8'h01, 8'h00, 3'd0, 8'h00, 8'h0F, 1'b1, 8'h20},
        {4'h3, 8'h00, 8'h00, 8'h00, 3'd0, 8'h03, 8'hFF, 1'b1, 8'h35},
        {4'h6, 8'h05, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00},
        {4'h6, 8'h05, 8'h05, 8'h00, 3'd0, 8'h02, 8'h00, 1'b0, 8'h02},
        {4'h7, 8'h80, 8'h01, 8'h00, 3'd0, 8'h00, 8'h7F, 1'b0, 8'h38},
        {4'h8, 8'h7F, 8'h00, 8'h00, 3'd0, 8'h01, 8'h80, 1'b1, 8'h0D},
        {4'h9, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 8'hFF, 1'b1, 8'h14},
        {4'hA, 8'hF0, 8'h0F, 8'h00, 3'd0, 8'h29, 8'h00, 1'b1, 8'h23},
        {4'hC, 8'hAA, 8'h55, 8'h00, 3'd0, 8'h00, 8'hFF, 1'b1, 8'h14},
        {4'hD, 8'h08, 8'h00, 8'h00, 3'd3, 8'h00, 8'h08, 1'b0, 8'h40},
        {4'hE, 8'h00, 8'h00, 8'h00, 3'd7, 8'h40, 8'h80, 1'b1, 8'h40},
        {4'h4, 8'h03, 8'h01, 8'h05, 3'd0, 8'h80, 8'hFE, 1'b1, 8'hB5},
        {4'hF, 8'h12, 8'h34, 8'h00, 3'd0, 8'h5A, 8'h12, 1'b0, 8'h5A},
        {4'hB, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 1'b1, 8'h02}
    };
    string vtag [NV] = '{"R1", "R1", "R2", "R2", "R3", "R3", "R4", "R5",
                         "R5", "R6", "R6", "R7", "R7", "R9", "R10", "R12"};

    task automatic check(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, got, exp);
        end
    endtask

    // Drive at a falling edge; outputs settle after the next rising edge.
    task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] im, input logic [2:0] s, input logic [7:0] st);
        @(negedge clk);
        in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; imm = im; bit_sel = s; status_in = st;
        @(negedge clk);
    endtask

    // Independent reference: returns {we, result, status}.
    function automatic logic [16:0] ref_alu(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                                            input logic [7:0] im, input logic [2:0] s, input logic [7:0] st);
        int ua, ub, cin, sum, sa, sb, ss, la, lb;
        logic [7:0] r = a;
        logic [7:0] f = st;
        logic we = 1'b0;
        logic upd = 1'b0;
        logic zkeep = 1'b0;
        ua = a;
        ub = (o == 4'h4 || o == 4'h5) ? int'(im) : int'(b);
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        la = ua % 16;
        lb = ub % 16;
        case (o)
            4'h0, 4'h1: begin
                cin = (o == 4'h1) ? int'(st[0]) : 0;
                sum = ua + ub + cin;
                r = 8'(sum);
                f[0] = sum > 255;
                f[5] = (la + lb + cin) > 15;
                ss = sa + sb + cin;
                f[3] = (ss > 127) || (ss < -128);
                upd = 1'b1; we = 1'b1;
            end
            4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: begin
                cin = (o == 4'h3 || o == 4'h5 || o == 4'h6) ? int'(st[0]) : 0;
                zkeep = (o == 4'h3 || o == 4'h5 || o == 4'h6);
                sum = ua - ub - cin;
                r = 8'(sum);
                f[0] = sum < 0;
                f[5] = (la - lb - cin) < 0;
                ss = sa - sb - cin;
                f[3] = (ss > 127) || (ss < -128);
                upd = 1'b1; we = (o != 4'h6 && o != 4'h7);
            end
            4'h8: begin r = 8'(ua + 1); f[3] = (sa + 1) > 127;  upd = 1'b1; we = 1'b1; end
            4'h9: begin r = 8'(ua - 1); f[3] = (sa - 1) < -128; upd = 1'b1; we = 1'b1; end
            4'hA: begin r = a & b; f[3] = 1'b0; upd = 1'b1; we = 1'b1; end
            4'hB: begin r = a | b; f[3] = 1'b0; upd = 1'b1; we = 1'b1; end
            4'hC: begin r = a ^ b; f[3] = 1'b0; upd = 1'b1; we = 1'b1; end
            4'hD: f[6] = a[s];
            4'hE: begin r[s] = st[6]; we = 1'b1; end
            default: ;
        endcase
        if (upd) begin
            f[1] = zkeep ? (st[1] && r == 8'h00) : (r == 8'h00);
            f[2] = r[7];
            f[4] = f[2] ^ f[3];
        end
        return {we, r, f};
    endfunction

    // 32-bit compare chain: CP on the low byte, then CPC on each higher byte.
    task automatic chain32(input logic [31:0] x, input logic [31:0] y, input string tag);
        logic [7:0] st = 8'h00;
        for (int i = 0; i < 4; i++) begin
            apply((i == 0) ? 4'h7 : 4'h6, x[8*i +: 8], y[8*i +: 8], 8'h00, 3'd0, st);
            st = status_out;
        end
        check(tag, "chain Z", {7'd0, st[1]}, {7'd0, x == y});
        check(tag, "chain C", {7'd0, st[0]}, {7'd0, x < y});
    endtask

    initial begin
        logic [16:0] exp;
        // R11: reset clears outputs even with an op presented.
        in_valid = 1'b1; op = 4'h0; opnd_a = 8'h11; opnd_b = 8'h22; status_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R11", "reset out_valid", {7'd0, out_valid}, 8'h00);
        check("R11", "reset wr_en", {7'd0, wr_en}, 8'h00);
        check("R11", "reset result", result, 8'h00);
        check("R11", "reset status", status_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "latency valid", {7'd0, out_valid}, 8'h01);
        check("R11", "latency result", result, 8'h33);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][55:52], VEC[i][51:44], VEC[i][43:36], VEC[i][35:28],
                  VEC[i][27:25], VEC[i][24:17]);
            check(vtag[i], "table result", result, VEC[i][16:9]);
            check(vtag[i], "table wr_en", {7'd0, wr_en}, {7'd0, VEC[i][8]});
            check(vtag[i], "table status", status_out, VEC[i][7:0]);
        end

        // R11: idle cycle gives no write.
        @(negedge clk); in_valid = 1'b0; op = 4'h0;
        @(negedge clk);
        check("R11", "idle wr_en", {7'd0, wr_en}, 8'h00);
        check("R11", "idle valid", {7'd0, out_valid}, 8'h00);

        // R3 chained 32-bit compares.
        chain32(32'h12345678, 32'h12345677, "R3");
        chain32(32'hCAFE0102, 32'hCAFE0102, "R3");
        chain32(32'h00345678, 32'h01345678, "R3");

        // R2/R9: immediate ops ignore opnd_b, register ops ignore imm.
        apply(4'h5, 8'h40, 8'hFF, 8'h10, 3'd0, 8'h01);
        check("R9", "SBCI uses imm", result, 8'h2F);
        apply(4'h2, 8'h40, 8'h10, 8'hFF, 3'd0, 8'h00);
        check("R9", "SUB ignores imm", result, 8'h30);

        // Random comparison across all ops (R1..R12).
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] o; logic [7:0] a, b, im, st; logic [2:0] s;
            o = 4'($urandom); a = 8'($urandom); b = 8'($urandom);
            im = 8'($urandom); s = 3'($urandom); st = 8'($urandom);
            if (n % 7 == 0) b = a;
            apply(o, a, b, im, s, st);
            exp = ref_alu(o, a, b, im, s, st);
            check("R1-R12 random", "result", result, exp[15:8]);
            check("R4 random", "wr_en", {7'd0, wr_en}, {7'd0, exp[16]});
            check("R8 random", "status", status_out, exp[7:0]);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule